// File: doc/BRIEF.md
# Selectable-Operand Arithmetic Microoperation Unit

This block is a purely combinational arithmetic unit. Operand `op_a` drives one side of a ripple-carry adder with no logic in between. The other side of the adder takes a second operand that a shared two-bit selector picks for every bit position. The choices are `op_b`, its bitwise complement, all zeros or all ones. The carry input enters the least significant stage. So the result is always `op_a + Y + carry_in`, and the eight combinations of selector and carry give eight arithmetic microoperations from a single adder: add, add plus one, subtract with borrow, subtract, increment, decrement, and two forms of transfer.

A datapath controller drives the select code and carry and reads the result in the same cycle. There is no clock, no reset and no stored state. The operand width is the parameter `WIDTH` (default 4). The selectors and the carry chain scale with it.

Top module: `arith_micro_unit`

## Requirements
- R1: With `op_sel`=2'b00 and `carry_in`=0, `result` = (`op_a`+`op_b`) mod 2^WIDTH and `carry_out` is the carry out of bit WIDTH-1 of that sum.
- R2: With `op_sel`=2'b00 and `carry_in`=1, `result` = (`op_a`+`op_b`+1) mod 2^WIDTH, and `carry_out` is the carry out of that sum.
- R3: With `op_sel`=2'b01 and `carry_in`=0, `result` = (`op_a`-`op_b`-1) mod 2^WIDTH, and `carry_out`=1 exactly when `op_a` > `op_b` (unsigned).
- R4: With `op_sel`=2'b01 and `carry_in`=1, `result` = (`op_a`-`op_b`) mod 2^WIDTH, and `carry_out`=1 exactly when `op_a` >= `op_b` (unsigned).
- R5: With `op_sel`=2'b10 and `carry_in`=0, `result` = `op_a` and `carry_out`=0.
- R6: With `op_sel`=2'b10 and `carry_in`=1, `result` = (`op_a`+1) mod 2^WIDTH, and `carry_out`=1 only when `op_a` is all ones.
- R7: With `op_sel`=2'b11 and `carry_in`=0, `result` = (`op_a`-1) mod 2^WIDTH, and `carry_out`=0 only when `op_a` is zero.
- R8: With `op_sel`=2'b11 and `carry_in`=1, `result` = `op_a` and `carry_out`=1.
- R9: The outputs follow any input change within the same cycle, with no clock edge in between.
- R10: With `op_sel`=2'b10 or 2'b11, the value of `op_b` has no effect on `result` or `carry_out`.
- R11: With `WIDTH`=8, every rule R1 to R8 holds over 8-bit operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Operand fed straight into the adder |
| op_b | input | WIDTH | Operand that the per-bit selector may pass or complement |
| op_sel | input | 2 | Second-operand choice: 00 op_b, 01 ~op_b, 10 zeros, 11 ones |
| carry_in | input | 1 | Carry into the least significant stage |
| result | output | WIDTH | Sum op_a + Y + carry_in, truncated to WIDTH bits |
| carry_out | output | 1 | Carry from the most significant stage |

## Verification
The bench aims at the cases where the carry crosses the whole width. These are all-ones plus one, zero minus one, and equal operands under subtraction. A stage wired with a broken carry link returns a result that is off by a power of two, and a misplaced complement turns the borrow sense of `carry_out` upside down. The swapped pairs of select codes, such as zeros against ones or `op_b` against its complement, are told apart by their results. A selector that leaks `op_b` into the transfer, increment or decrement modes is caught by changing only `op_b` and watching for any output change. A second instance at 8 bits catches logic that was sized for four bits and does not follow the parameter.

// File: rtl/arith_pkg.sv
// Package: shared types for the arithmetic microoperation unit.
// Assumes: the two-bit select code is decoded the same way by every bit slice.
package arith_pkg;

    // Choice of second adder operand, one code for all bit positions.
    typedef enum logic [1:0] {
        YSEL_PASS = 2'b00,   // Y = B
        YSEL_INV  = 2'b01,   // Y = ~B
        YSEL_ZERO = 2'b10,   // Y = all zeros
        YSEL_ONES = 2'b11    // Y = all ones
    } ysel_e;

endpackage

// File: rtl/y_operand_select.sv
// Module: y_operand_select
// Builds the second adder operand one bit at a time. Every slice is a 4:1
// choice between the B bit, its complement, 0 and 1, driven by a common code.
// Assumes: sel is a legal ysel_e code (all four codes are legal).
module y_operand_select
    import arith_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] b_in,
    input  ysel_e            sel,
    output logic [WIDTH-1:0] y_out
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_slice
            // Per-bit 4:1 operand choice.
            always_comb begin
                unique case (sel)
                    YSEL_PASS: y_out[gi] = b_in[gi];
                    YSEL_INV:  y_out[gi] = ~b_in[gi];
                    YSEL_ZERO: y_out[gi] = 1'b0;
                    YSEL_ONES: y_out[gi] = 1'b1;
                    default:   y_out[gi] = 1'b0;
                endcase
            end
        end
    endgenerate

    // Guard: the zero and ones codes must give uniform vectors with no trace of B.
    always_comb begin
        if (sel == YSEL_ZERO) begin
            AST_ZERO_OPERAND: assert (y_out == '0)
                else $error("Y not all zeros for zero code"); // R10
        end
        if (sel == YSEL_ONES) begin
            AST_ONES_OPERAND: assert (y_out == '1)
                else $error("Y not all ones for ones code"); // R10
        end
    end

endmodule

// File: rtl/full_adder_cell.sv
// Module: full_adder_cell
// One-bit full adder: sum and carry of x, y and a carry input.
// Assumes: nothing; pure gate logic.
module full_adder_cell (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);

    // Sum and majority carry of the three inputs.
    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (x & ci) | (y & ci);
    end

endmodule

// File: rtl/ripple_adder.sv
// Module: ripple_adder
// WIDTH-bit ripple-carry adder made of full_adder_cell stages. Stage k passes
// its carry to stage k+1; the last stage's carry is the adder carry-out.
// Assumes: WIDTH >= 1.
module ripple_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum,
    output logic             c_out
);

    logic [WIDTH:0] chain;

    // Seed the chain with the external carry.
    always_comb chain[0] = c_in;

    genvar gk;
    generate
        for (gk = 0; gk < WIDTH; gk++) begin : g_stage
            full_adder_cell u_fa (
                .x  (x_in[gk]),
                .y  (y_in[gk]),
                .ci (chain[gk]),
                .s  (sum[gk]),
                .co (chain[gk+1])
            );
        end
    endgenerate

    // Carry from the top stage leaves the adder.
    always_comb c_out = chain[WIDTH];

    // Guard: the bit-level chain must equal a word-level sum.
    always_comb begin
        AST_CHAIN_SUM: assert ({c_out, sum} ==
                               ({1'b0, x_in} + {1'b0, y_in} + {{WIDTH{1'b0}}, c_in}))
            else $error("ripple chain disagrees with word sum"); // R1
    end

endmodule

// File: rtl/arith_micro_unit.sv
// Module: arith_micro_unit
// Combinational arithmetic microoperation unit: result = op_a + Y + carry_in,
// where Y is op_b, ~op_b, zeros or ones chosen by op_sel.
// Assumes: inputs are stable for the settling time of a WIDTH-stage ripple.
module arith_micro_unit
    import arith_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [1:0]       op_sel,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    localparam logic [WIDTH-1:0] ONE_W = {{(WIDTH-1){1'b0}}, 1'b1};

    ysel_e            sel_code;
    logic [WIDTH-1:0] y_bus;

    // Map the raw select pins onto the shared code type.
    always_comb sel_code = ysel_e'(op_sel);

    y_operand_select #(.WIDTH(WIDTH)) u_ysel (
        .b_in  (op_b),
        .sel   (sel_code),
        .y_out (y_bus)
    );

    ripple_adder #(.WIDTH(WIDTH)) u_add (
        .x_in  (op_a),
        .y_in  (y_bus),
        .c_in  (carry_in),
        .sum   (result),
        .c_out (carry_out)
    );

    // Guard: microoperation results seen at the ports.
    always_comb begin
        if (sel_code == YSEL_ZERO && !carry_in) begin
            AST_TRANSFER_ZERO: assert (result == op_a && !carry_out)
                else $error("transfer with zero operand broken"); // R5
        end
        if (sel_code == YSEL_ONES && carry_in) begin
            AST_TRANSFER_ONES: assert (result == op_a && carry_out)
                else $error("transfer with ones operand broken"); // R8
        end
        if (sel_code == YSEL_INV && carry_in) begin
            AST_SUBTRACT: assert (result == op_a - op_b && carry_out == (op_a >= op_b))
                else $error("subtract result or borrow wrong"); // R4
        end
        if (sel_code == YSEL_ONES && !carry_in) begin
            AST_DECREMENT: assert (result == op_a - ONE_W && carry_out == (op_a != '0))
                else $error("decrement result or carry wrong"); // R7
        end
    end

endmodule

// File: tb/arith_micro_unit_test.sv
// Bench for arith_micro_unit: vector table, exhaustive sweep, directed cases.
module arith_micro_unit_test;

    localparam int W  = 4;
    localparam int WW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;   // 100 MHz

    logic [W-1:0]  a, b, d;
    logic [1:0]    sel;
    logic          cin, cout;
    logic [WW-1:0] a8, b8, d8;
    logic [1:0]    sel8;
    logic          cin8, cout8;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    arith_micro_unit #(.WIDTH(W)) uut (
        .op_a(a), .op_b(b), .op_sel(sel), .carry_in(cin),
        .result(d), .carry_out(cout)
    );

    arith_micro_unit #(.WIDTH(WW)) uut_wide (
        .op_a(a8), .op_b(b8), .op_sel(sel8), .carry_in(cin8),
        .result(d8), .carry_out(cout8)
    );

    // Vector: [15:14] sel, [13] cin, [12:9] a, [8:5] b, [4:1] d, [0] cout.
    localparam int NV = 16;
    localparam logic [15:0] VEC [NV] = '{
        {2'b00, 1'b0, 4'h3, 4'h5, 4'h8, 1'b0},  // R1
        {2'b00, 1'b0, 4'h9, 4'h8, 4'h1, 1'b1},  // R1 carry out
        {2'b00, 1'b1, 4'hF, 4'h0, 4'h0, 1'b1},  // R2 full ripple
        {2'b00, 1'b1, 4'h0, 4'h0, 4'h1, 1'b0},  // R2
        {2'b01, 1'b0, 4'h7, 4'h2, 4'h4, 1'b1},  // R3 a > b
        {2'b01, 1'b0, 4'h2, 4'h2, 4'hF, 1'b0},  // R3 a == b
        {2'b01, 1'b0, 4'h0, 4'hF, 4'h0, 1'b0},  // R3 wrap
        {2'b01, 1'b1, 4'h7, 4'h2, 4'h5, 1'b1},  // R4
        {2'b01, 1'b1, 4'h2, 4'h7, 4'hB, 1'b0},  // R4 negative
        {2'b01, 1'b1, 4'h4, 4'h4, 4'h0, 1'b1},  // R4 equal
        {2'b10, 1'b0, 4'hA, 4'h5, 4'hA, 1'b0},  // R5
        {2'b10, 1'b1, 4'hF, 4'h3, 4'h0, 1'b1},  // R6 overflow
        {2'b10, 1'b1, 4'h6, 4'h9, 4'h7, 1'b0},  // R6
        {2'b11, 1'b0, 4'h0, 4'h6, 4'hF, 1'b0},  // R7 underflow
        {2'b11, 1'b0, 4'h8, 4'hE, 4'h7, 1'b1},  // R7
        {2'b11, 1'b1, 4'hC, 4'h1, 4'hC, 1'b1}   // R8
    };

    // Reference: the operation each select/carry pair names, at any width.
    function automatic logic [WW:0] ref_op(input logic [1:0] s, input logic c,
                                           input logic [WW-1:0] x, input logic [WW-1:0] y,
                                           input int w);
        longint unsigned m, r;
        m = (longint'(1) << w);
        case (s)
            2'b00:   r = x + y + c;
            2'b01:   r = x + ((m - 1) - y) + c;
            2'b10:   r = x + c;
            default: r = x + (m - 1) + c;
        endcase
        return (WW+1)'(r % (m * 2));
    endfunction

    task automatic check(input string tag, input logic [WW:0] act, input logic [WW:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive4(input logic [1:0] s, input logic c, input logic [W-1:0] x,
                          input logic [W-1:0] y);
        @(negedge clk);
        sel = s; cin = c; a = x; b = y;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; sel = 2'b00; cin = 1'b0;
        a8 = '0; b8 = '0; sel8 = 2'b00; cin8 = 1'b0;
        #2;
        // Idle state with all-zero inputs: R1 gives zero sum, no carry.
        check("R1 idle", {{(WW-W){1'b0}}, cout, d}, '0);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            logic [15:0] v;
            string t;
            v = VEC[i];
            drive4(v[15:14], v[13], v[12:9], v[8:5]);
            t = $sformatf("R%0d vec%0d", v[15:14] * 2 + v[13] + 1, i);
            check(t, {{(WW-W){1'b0}}, cout, d}, {{(WW-W){1'b0}}, v[0], v[4:1]});
        end

        // Exhaustive sweep at WIDTH=4 covering R1 through R8.
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 2; c++)
                for (int x = 0; x < 16; x++)
                    for (int y = 0; y < 16; y++) begin
                        logic [WW:0] e;
                        drive4(2'(s), 1'(c), 4'(x), 4'(y));
                        e = ref_op(2'(s), 1'(c), WW'(x), WW'(y), W);
                        check($sformatf("R%0d sweep", s * 2 + c + 1),
                              {{(WW-W){1'b0}}, cout, d}, e);
                    end

        // R10: op_b changes with zeros/ones codes leave outputs unchanged.
        for (int s = 2; s < 4; s++)
            for (int c = 0; c < 2; c++) begin
                logic [W:0] first;
                drive4(2'(s), 1'(c), 4'h5, 4'h0);
                first = {cout, d};
                for (int y = 1; y < 16; y++) begin
                    drive4(2'(s), 1'(c), 4'h5, 4'(y));
                    check("R10 op_b ignored", {{(WW-W){1'b0}}, cout, d},
                          {{(WW-W){1'b0}}, first});
                end
            end

        // R9: outputs change with no clock edge between input changes.
        @(negedge clk);
        sel = 2'b00; cin = 1'b0; a = 4'h1; b = 4'h1;
        #1;
        check("R9 settle 1", {{(WW-W){1'b0}}, cout, d}, 9'h002);
        a = 4'hF;
        #1;
        check("R9 settle 2", {{(WW-W){1'b0}}, cout, d}, 9'h010);
        cin = 1'b1;
        #1;
        check("R9 settle 3", {{(WW-W){1'b0}}, cout, d}, 9'h011);

        // R11: 8-bit instance, edges and pseudo-random operands.
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 2; c++)
                for (int k = 0; k < 40; k++) begin
                    logic [WW-1:0] x, y;
                    x = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'($urandom);
                    y = (k == 0) ? 8'hFF : (k == 1) ? 8'hFF : 8'($urandom);
                    @(negedge clk);
                    sel8 = 2'(s); cin8 = 1'(c); a8 = x; b8 = y;
                    #1;
                    check("R11 wide", {cout8, d8}, ref_op(2'(s), 1'(c), x, y, WW));
                end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule